// File: doc/BRIEF.md
# Hashed Two-Port Bank Request Router

This block sits in front of a cache that is split into several single-ported banks. Each cycle it accepts up to two access requests. Each request carries an address and a payload. The block works out which bank each request targets and forwards it on that bank's registered request port. When both requests name the same bank in the same cycle, only one is forwarded. The other is held at its port and goes through on the following cycle. No request is lost.

The bank number comes from the lowest bits of the line index. In hashed mode the lowest bits of the tag are XORed into them. This spreads strided address streams, which would otherwise pile onto a single bank, across all the banks. Each forwarded request is tagged with the number of the port it came from, so that the bank's response can be returned to the right requester.

The request ports follow valid/ready rules. A port whose valid is high while its ready is low must keep its address and payload unchanged until ready is high.

Top module: `hashed_bank_router`

## Requirements
- R1: While reset is held, and in the first cycle after reset with no request valid, every bank valid output is 0 and both port readys are 1.
- R2: With hashing enabled (default), a request to address A is forwarded on bank A[7:6] XOR A[15:14]. The defaults are a 64-byte line, 8 index bits and 4 banks.
- R3: With hashing disabled, a request to address A is forwarded on bank A[7:6].
- R4: Two valid requests to different banks in the same cycle are both accepted (both readys 1). At most two bank valid outputs are high in any cycle.
- R5: When both ports target the same bank and port 1 did not lose the previous cycle, port 0 is accepted and port 1's ready is 0.
- R6: A port that was refused in one cycle is accepted in the next cycle, even against a new same-bank request on the other port. In that case port 1 wins over port 0.
- R7: A forwarded request appears on its bank's outputs in the cycle after its handshake, for exactly one cycle. It carries the original address and payload, and a source bit of 0 for port 0 or 1 for port 1.
- R8: Every accepted request is forwarded exactly once. Nothing appears on a bank output without a prior handshake.
- R9: With two uniformly random addresses presented together, about one pair in four collides on a bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_valid | input | 1 | Port 0 request valid |
| p0_ready | output | 1 | Port 0 accepted (grant); low means stall |
| p0_addr | input | AW | Port 0 byte address |
| p0_data | input | DW | Port 0 payload |
| p1_valid | input | 1 | Port 1 request valid |
| p1_ready | output | 1 | Port 1 accepted (grant); low means stall |
| p1_addr | input | AW | Port 1 byte address |
| p1_data | input | DW | Port 1 payload |
| bank_valid | output | NUM_BANKS | One request strobe per bank |
| bank_addr | output | NUM_BANKS*AW | Forwarded address, bank b at [b*AW +: AW] |
| bank_data | output | NUM_BANKS*DW | Forwarded payload, bank b at [b*DW +: DW] |
| bank_src | output | NUM_BANKS | Originating port of each bank's request |

## Verification
The hardest case to reach is the one where the priority flips. Port 1 must have just lost a collision, and port 0 must then present a fresh request to that same bank while port 1 still waits. A directed sequence sets this up: it chooses two addresses whose hashed banks match, then replaces port 0's request right after its grant. Hash correctness is tested with addresses whose tag bits cancel or flip the index bits. The plain-mode variant gets its own instance. Random pairs then measure the collision rate against the expected one in four.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  typedef enum logic {SRC_P0 = 1'b0, SRC_P1 = 1'b1} src_e;
endpackage

// File: rtl/hbr_bank_hash.sv
module hbr_bank_hash #(
  parameter int BB      = 2,
  parameter bit HASH_EN = 1'b1
) (
  input  logic [BB-1:0] idx_lo,
  input  logic [BB-1:0] tag_lo,
  output logic [BB-1:0] bank
);
  localparam logic [BB-1:0] TAG_MASK = HASH_EN ? {BB{1'b1}} : {BB{1'b0}};
  assign bank = idx_lo ^ (tag_lo & TAG_MASK);
endmodule

// File: rtl/hbr_arbiter.sv
module hbr_arbiter #(
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v0,
  input  logic          v1,
  input  logic [BB-1:0] b0,
  input  logic [BB-1:0] b1,
  output logic          rdy0,
  output logic          rdy1
);
  logic clash;
  logic p1_owed_q;

  assign clash = v0 && v1 && (b0 == b1);
  assign rdy0  = !(clash && p1_owed_q);
  assign rdy1  = !(clash && !p1_owed_q);

  always_ff @(posedge clk) begin
    if (rst) p1_owed_q <= 1'b0;
    else     p1_owed_q <= v1 && !rdy1;
  end

  AST_SPLIT_BANKS_BOTH_GO: assert property (@(posedge clk) disable iff (rst)
    (v0 && v1 && b0 != b1) |-> (rdy0 && rdy1)); // R4
  AST_CLASH_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
    (v0 && v1) |-> (rdy0 || rdy1)); // R5
  AST_P1_LOSER_NEXT: assert property (@(posedge clk) disable iff (rst)
    (v1 && !rdy1) |=> rdy1); // R6
  AST_P0_LOSER_NEXT: assert property (@(posedge clk) disable iff (rst)
    (v0 && !rdy0) |=> rdy0); // R6
endmodule

// File: rtl/hbr_out_stage.sv
module hbr_out_stage
  import hbr_pkg::*;
#(
  parameter int NB = 4,
  parameter int BB = 2,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go0,
  input  logic           go1,
  input  logic [BB-1:0]  b0,
  input  logic [BB-1:0]  b1,
  input  logic [AW-1:0]  a0,
  input  logic [AW-1:0]  a1,
  input  logic [DW-1:0]  d0,
  input  logic [DW-1:0]  d1,
  output logic [NB-1:0]    q_valid,
  output logic [NB*AW-1:0] q_addr,
  output logic [NB*DW-1:0] q_data,
  output logic [NB-1:0]    q_src
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic          hit0, hit1;
    logic          vld_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    src_e          src_q;

    assign hit0 = go0 && (b0 == BB'(b));
    assign hit1 = go1 && (b1 == BB'(b));

    always_ff @(posedge clk) begin
      if (rst) vld_q <= 1'b0;
      else     vld_q <= hit0 || hit1;
    end

    always_ff @(posedge clk) begin
      if (hit0) begin
        addr_q <= a0;
        data_q <= d0;
        src_q  <= SRC_P0;
      end else if (hit1) begin
        addr_q <= a1;
        data_q <= d1;
        src_q  <= SRC_P1;
      end
    end

    assign q_valid[b]          = vld_q;
    assign q_addr[b*AW +: AW]  = addr_q;
    assign q_data[b*DW +: DW]  = data_q;
    assign q_src[b]            = src_q;

    AST_BANK_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (rst)
      !(hit0 && hit1)); // R4
  end
endmodule

// File: rtl/hashed_bank_router.sv
module hashed_bank_router #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int NUM_BANKS  = 4,
  parameter int INDEX_BITS = 8,
  parameter bit HASH_EN    = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  p0_valid,
  output logic                  p0_ready,
  input  logic [AW-1:0]         p0_addr,
  input  logic [DW-1:0]         p0_data,
  input  logic                  p1_valid,
  output logic                  p1_ready,
  input  logic [AW-1:0]         p1_addr,
  input  logic [DW-1:0]         p1_data,
  output logic [NUM_BANKS-1:0]    bank_valid,
  output logic [NUM_BANKS*AW-1:0] bank_addr,
  output logic [NUM_BANKS*DW-1:0] bank_data,
  output logic [NUM_BANKS-1:0]    bank_src
);
  localparam int OFF_BITS = $clog2(LINE_BYTES);
  localparam int BB       = $clog2(NUM_BANKS);
  localparam int TAG_LSB  = OFF_BITS + INDEX_BITS;

  logic [1:0]          vld;
  logic [1:0][AW-1:0]  addr;
  logic [1:0][BB-1:0]  bsel;
  logic                go0, go1;

  assign vld  = {p1_valid, p0_valid};
  assign addr = {p1_addr, p0_addr};

  for (genvar p = 0; p < 2; p++) begin : g_port
    hbr_bank_hash #(.BB(BB), .HASH_EN(HASH_EN)) u_hash (
      .idx_lo (addr[p][OFF_BITS +: BB]),
      .tag_lo (addr[p][TAG_LSB +: BB]),
      .bank   (bsel[p])
    );
  end

  hbr_arbiter #(.BB(BB)) u_arb (
    .clk  (clk),
    .rst  (rst),
    .v0   (vld[0]),
    .v1   (vld[1]),
    .b0   (bsel[0]),
    .b1   (bsel[1]),
    .rdy0 (p0_ready),
    .rdy1 (p1_ready)
  );

  assign go0 = p0_valid && p0_ready;
  assign go1 = p1_valid && p1_ready;

  hbr_out_stage #(.NB(NUM_BANKS), .BB(BB), .AW(AW), .DW(DW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .go0     (go0),
    .go1     (go1),
    .b0      (bsel[0]),
    .b1      (bsel[1]),
    .a0      (p0_addr),
    .a1      (p1_addr),
    .d0      (p0_data),
    .d1      (p1_data),
    .q_valid (bank_valid),
    .q_addr  (bank_addr),
    .q_data  (bank_data),
    .q_src   (bank_src)
  );

  AST_HELD_P0_STABLE: assert property (@(posedge clk) disable iff (rst)
    (p0_valid && !p0_ready) |=> (p0_valid && $stable(p0_addr) && $stable(p0_data))); // R6
  AST_HELD_P1_STABLE: assert property (@(posedge clk) disable iff (rst)
    (p1_valid && !p1_ready) |=> (p1_valid && $stable(p1_addr) && $stable(p1_data))); // R6
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (rst)
    (|bank_valid) |-> $past(go0 || go1)); // R8
  AST_OUT_COUNT: assert property (@(posedge clk) disable iff (rst)
    $countones(bank_valid) <= $past(32'(go0) + 32'(go1))); // R4
endmodule

// File: tb/hashed_bank_router_bench.sv
module hashed_bank_router_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NB = 4;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          s;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          p0_valid = 0, p1_valid = 0, p0_ready, p1_ready;
  logic [AW-1:0] p0_addr = 0, p1_addr = 0;
  logic [DW-1:0] p0_data = 0, p1_data = 0;
  logic [NB-1:0]    bank_valid, bank_src;
  logic [NB*AW-1:0] bank_addr;
  logic [NB*DW-1:0] bank_data;

  logic          pl_valid = 0, pl_ready, pl_r1;
  logic [AW-1:0] pl_addr = 0;
  logic [DW-1:0] pl_data = 0;
  logic [NB-1:0]    pl_bvalid, pl_bsrc;
  logic [NB*AW-1:0] pl_baddr;
  logic [NB*DW-1:0] pl_bdata;

  hashed_bank_router u_hashed_bank_router (
    .clk(clk), .rst(rst),
    .p0_valid(p0_valid), .p0_ready(p0_ready), .p0_addr(p0_addr), .p0_data(p0_data),
    .p1_valid(p1_valid), .p1_ready(p1_ready), .p1_addr(p1_addr), .p1_data(p1_data),
    .bank_valid(bank_valid), .bank_addr(bank_addr), .bank_data(bank_data), .bank_src(bank_src)
  );

  hashed_bank_router #(.HASH_EN(1'b0)) u_hashed_bank_router_plain (
    .clk(clk), .rst(rst),
    .p0_valid(pl_valid), .p0_ready(pl_ready), .p0_addr(pl_addr), .p0_data(pl_data),
    .p1_valid(1'b0), .p1_ready(pl_r1), .p1_addr('0), .p1_data('0),
    .bank_valid(pl_bvalid), .bank_addr(pl_baddr), .bank_data(pl_bdata), .bank_src(pl_bsrc)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  item_t exp_q [NB][$];

  function automatic int hbank(input logic [AW-1:0] a);
    return int'(a[7:6] ^ a[15:14]);
  endfunction

  function automatic void push_exp(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic s);
    item_t it;
    it.a = a; it.d = d; it.s = s;
    exp_q[hbank(a)].push_back(it);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Scoreboard monitor: each bank strobe must match the oldest expected item for that bank.
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      for (int b = 0; b < NB; b++) begin
        if (bank_valid[b]) begin
          if (exp_q[b].size() == 0) begin
            check(1'b0, "R2/R8 unexpected request on bank", 64'(b), 64'hFFFF);
          end else begin
            item_t e;
            e = exp_q[b].pop_front();
            check(bank_addr[b*AW +: AW] == e.a, "R2 bank address", 64'(bank_addr[b*AW +: AW]), 64'(e.a));
            check(bank_data[b*DW +: DW] == e.d, "R7 bank payload", 64'(bank_data[b*DW +: DW]), 64'(e.d));
            check(bank_src[b] == e.s, "R7 source port", 64'(bank_src[b]), 64'(e.s));
          end
        end
      end
    end
  end

  // Drive a pair; returns the cycle index (0 = first) in which each port was accepted.
  task automatic send(input logic v0, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                      input logic v1, input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                      output int c0, output int c1);
    bit pend0, pend1;
    int n;
    pend0 = v0; pend1 = v1; n = 0; c0 = -1; c1 = -1;
    @(negedge clk);
    p0_addr = a0; p0_data = d0; p1_addr = a1; p1_data = d1;
    while (pend0 || pend1) begin
      p0_valid = pend0; p1_valid = pend1;
      #5;
      if (pend0 && p0_ready) begin push_exp(a0, d0, 1'b0); pend0 = 0; c0 = n; end
      if (pend1 && p1_ready) begin push_exp(a1, d1, 1'b1); pend1 = 0; c1 = n; end
      @(posedge clk);
      @(negedge clk);
      n++;
      if (n > 8) begin pend0 = 0; pend1 = 0; end
    end
    p0_valid = 0; p1_valid = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0, c1, clashes;
    repeat (3) @(posedge clk);
    #5;
    check(bank_valid == 0, "R1 bank valid in reset", 64'(bank_valid), 0);
    @(negedge clk) rst = 0;
    @(negedge clk);
    #5;
    check(bank_valid == 0, "R1 bank valid after reset", 64'(bank_valid), 0);
    check(p0_ready && p1_ready, "R1 readys idle", 64'({p0_ready, p1_ready}), 64'h3);

    // R2: hash cases, single port each
    send(1, 32'h0000_0040, 32'hA1, 0, 0, 0, c0, c1);   // bank 1
    send(0, 0, 0, 1, 32'h0000_4040, 32'hA2, c0, c1);   // 1^1 -> bank 0
    send(1, 32'h0000_C080, 32'hA3, 0, 0, 0, c0, c1);   // 2^3 -> bank 1
    check(c0 == 0, "R2 lone request accepted at once", 64'(c0), 0);

    // R3: plain instance, bank = A[7:6]
    @(negedge clk);
    pl_addr = 32'h0000_4040; pl_data = 32'hB3; pl_valid = 1;
    @(posedge clk);
    @(negedge clk);
    pl_valid = 0;
    check(pl_bvalid == 4'b0010, "R3 plain bank strobe", 64'(pl_bvalid), 64'h2);
    check(pl_baddr[1*AW +: AW] == 32'h0000_4040, "R3 plain bank address", 64'(pl_baddr[AW +: AW]), 64'h4040);
    @(negedge clk);
    check(pl_bvalid == 0, "R7 plain strobe lasts one cycle", 64'(pl_bvalid), 0);

    // R4: different banks in same cycle
    send(1, 32'h0000_0000, 32'hC0, 1, 32'h0000_00C0, 32'hC1, c0, c1);
    check(c0 == 0 && c1 == 0, "R4 split banks both accepted", 64'({c0[3:0], c1[3:0]}), 0);

    // R5: same bank, port 0 wins, port 1 next cycle
    send(1, 32'h0000_0080, 32'hD0, 1, 32'h0001_0080, 32'hD1, c0, c1);
    check(c0 == 0, "R5 port 0 wins clash", 64'(c0), 0);
    check(c1 == 1, "R5 port 1 deferred one cycle", 64'(c1), 1);

    // R6: port 1 owed, new port 0 request to the same bank loses
    @(negedge clk);
    p0_addr = 32'h0000_0080; p0_data = 32'hE0; p0_valid = 1;
    p1_addr = 32'h0000_C040; p1_data = 32'hE1; p1_valid = 1;   // 1^3 = 2, same bank
    #5;
    check(p0_ready && !p1_ready, "R5 initial clash", 64'({p0_ready, p1_ready}), 64'h2);
    push_exp(32'h0000_0080, 32'hE0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    p0_addr = 32'h0000_4000; p0_data = 32'hE2;                  // 0^1 ^... bank 1? adjust below
    p0_addr = 32'h0000_8000;                                    // 0^2 = bank 2
    #5;
    check(!p0_ready && p1_ready, "R6 owed port 1 beats new port 0", 64'({p0_ready, p1_ready}), 64'h1);
    push_exp(32'h0000_C040, 32'hE1, 1'b1);
    @(posedge clk);
    @(negedge clk);
    p1_valid = 0;
    #5;
    check(p0_ready, "R6 refused port 0 accepted next", 64'(p0_ready), 1);
    push_exp(32'h0000_8000, 32'hE2, 1'b0);
    @(posedge clk);
    @(negedge clk);
    p0_valid = 0;
    @(negedge clk);
    check(bank_valid == 0, "R7 strobes drop when idle", 64'(bank_valid), 0);

    // R9: random pairs, collision rate near one in four
    clashes = 0;
    for (int i = 0; i < 400; i++) begin
      send(1, $urandom, $urandom, 1, $urandom, $urandom, c0, c1);
      if (c0 != c1) clashes++;
    end
    check(clashes >= 70 && clashes <= 130, "R9 random collision count", 64'(clashes), 100);

    repeat (3) @(negedge clk);
    for (int b = 0; b < NB; b++)
      check(exp_q[b].size() == 0, "R8 all accepted requests forwarded", 64'(exp_q[b].size()), 0);
    check(bank_valid == 0, "R8 no output after drain", 64'(bank_valid), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule